// File: doc/BRIEF.md
# Paged Receive Ring Buffer Controller

This block stores incoming frames in a circular receive area of a byte-wide packet memory. The memory is divided into 256-byte pages. The ring runs from a programmable first page up to, but not including, a programmable stop page. Frames arrive as a byte stream with start-of-frame, end-of-frame and two error flags. Each frame is written into memory beginning at the current page.

The first four bytes of each frame's starting page are left free while the frame's bytes are written. When the frame ends, the block fills those four bytes with a header that gives:
- the receive status;
- the page where the next frame will begin;
- the 16-bit byte count.

Only after the header is written does the current-page pointer move forward.

The host frees space by moving a boundary register so that it trails its read position by one page. Before the block enters any page, it compares that page with the boundary. A frame that would run into the boundary page is dropped and an overwrite warning is raised. A small register port stands in for the host bus. Through it the host programs the ring limits, reads the pointers and clears the two interrupt flags.

Top module: `rx_page_ring`

## Requirements
- R1: After reset the start page reads PSTART_INIT, the stop page reads PSTOP_INIT, the current page equals PSTART_INIT, the boundary equals PSTOP_INIT-1 and the interrupt status reads 0.
- R2: Register map, with every register readable at its own address:
  - address 0: start page. A write also loads the current page with the same value.
  - address 1: stop page. A write also loads the boundary with the written value minus one.
  - address 2: boundary.
  - address 3: current page.
- R3: A frame's bytes are written one per accepted beat to consecutive addresses, beginning at byte offset 4 of the current page.
- R4: In the four cycles after the end-of-frame beat, the block writes the header to offsets 0,1,2,3 of the frame's starting page: status, next-frame page, byte count low, byte count high. Stream beats that arrive during those cycles are ignored.
- R5: Status byte: bit 0 set when neither error flag was present at end of frame, bit 1 copies the CRC error flag, bit 2 copies the alignment error flag, and the other bits are 0.
- R6: The stored byte count equals the number of stream bytes in the frame, which include the 4-byte check sequence.
- R7: After the last byte of page (stop-1), writing continues at offset 0 of the start page. No write ever falls outside [start, stop).
- R8: The current page changes to the page after the frame's last byte only at the fourth header write. Interrupt status bit 0 (frame received) is set at that same edge.
- R9: A frame that would write into the boundary page is dropped. This covers a start with current page equal to the boundary and a crossing into the boundary page. When it happens:
  - that page is not written;
  - interrupt status bit 4 (0x10) is set;
  - the current page stays unchanged and no header is written;
  - later beats are ignored until the next start-of-frame.
- R10: Interrupt status is read at address 4, with bit 0 = frame received and bit 4 = overwrite warning. Writing a 1 to a bit clears it. A set that falls in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| rx_valid | input | 1 | Stream beat valid |
| rx_sof | input | 1 | Beat is the first byte of a frame |
| rx_eof | input | 1 | Beat is the last byte of a frame |
| rx_data | input | 8 | Stream byte |
| rx_crc_err | input | 1 | CRC error flag, sampled with the end-of-frame beat |
| rx_align_err | input | 1 | Alignment error flag, sampled with the end-of-frame beat |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address {page, offset} |
| mem_wdata | output | 8 | Packet memory write data |
| irq_prx | output | 1 | Frame-received flag |
| irq_ovw | output | 1 | Overwrite-warning flag |

## Verification
Two functions can fall in the same cycle: the fourth header write, which sets the frame-received flag, and a host write that clears that flag. The bench provokes this by counting cycles from the end-of-frame beat and presenting the clear at the edge that completes the header. It then judges the result by reading the status register, where the flag must still be set. A separate clear, issued one cycle later, is expected to remove the flag. A second pair is a host boundary move and a page crossing. The bench keeps these apart, so that the drop test shows the crossing compared against a boundary that is already settled.

// File: rtl/rx_page_ring.sv
module rx_page_ring #(
  parameter logic [7:0] PSTART_INIT = 8'h40,
  parameter logic [7:0] PSTOP_INIT  = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        rx_crc_err,
  input  logic        rx_align_err,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        irq_prx,
  output logic        irq_ovw
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RECV = 2'd1, S_DROP = 2'd2, S_HDR = 2'd3} st_t;

  st_t         st_q;
  logic [7:0]  pstart_q, pstop_q, bnry_q, curr_q;
  logic [7:0]  wpg_q, woff_q, nxt_q, stat_q;
  logic [15:0] cnt_q, len_q;
  logic [1:0]  hidx_q;
  logic        prx_q, ovw_q;

  logic        take, blocked, store, hdr_done;
  logic [7:0]  pos_pg, pos_off, pg_inc, pg_wrap, npos_pg, npos_off, npos_inc, next_pkt;
  logic [15:0] cnt_base;
  logic [7:0]  hdr_byte;

  assign take     = rx_valid && (st_q != S_HDR) && (rx_sof || st_q == S_RECV);
  assign pos_pg   = rx_sof ? curr_q : wpg_q;
  assign pos_off  = rx_sof ? 8'd4 : woff_q;
  assign cnt_base = rx_sof ? 16'd0 : cnt_q;
  assign blocked  = rx_sof ? (curr_q == bnry_q) : (woff_q == 8'd0 && wpg_q == bnry_q);
  assign store    = take && !blocked;

  assign pg_inc   = pos_pg + 8'd1;
  assign pg_wrap  = (pg_inc == pstop_q) ? pstart_q : pg_inc;
  assign npos_off = pos_off + 8'd1;
  assign npos_pg  = (pos_off == 8'hFF) ? pg_wrap : pos_pg;
  assign npos_inc = npos_pg + 8'd1;
  assign next_pkt = (npos_off == 8'd0) ? npos_pg
                  : ((npos_inc == pstop_q) ? pstart_q : npos_inc);

  assign hdr_done = (st_q == S_HDR) && (hidx_q == 2'd3);

  always_comb begin
    case (hidx_q)
      2'd0:    hdr_byte = stat_q;
      2'd1:    hdr_byte = nxt_q;
      2'd2:    hdr_byte = len_q[7:0];
      default: hdr_byte = len_q[15:8];
    endcase
  end

  assign mem_we    = (st_q == S_HDR) || store;
  assign mem_addr  = (st_q == S_HDR) ? {curr_q, 6'd0, hidx_q} : {pos_pg, pos_off};
  assign mem_wdata = (st_q == S_HDR) ? hdr_byte : rx_data;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = pstart_q;
      3'd1:    reg_rdata = pstop_q;
      3'd2:    reg_rdata = bnry_q;
      3'd3:    reg_rdata = curr_q;
      3'd4:    reg_rdata = {3'd0, ovw_q, 3'd0, prx_q};
      default: reg_rdata = 8'd0;
    endcase
  end

  assign irq_prx = prx_q;
  assign irq_ovw = ovw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      wpg_q  <= 8'd0;
      woff_q <= 8'd0;
      cnt_q  <= 16'd0;
      hidx_q <= 2'd0;
      nxt_q  <= 8'd0;
      stat_q <= 8'd0;
      len_q  <= 16'd0;
    end else if (st_q == S_HDR) begin
      hidx_q <= hidx_q + 2'd1;
      if (hidx_q == 2'd3) st_q <= S_IDLE;
    end else if (take) begin
      if (blocked) begin
        st_q <= rx_eof ? S_IDLE : S_DROP;
      end else if (rx_eof) begin
        st_q   <= S_HDR;
        hidx_q <= 2'd0;
        nxt_q  <= next_pkt;
        len_q  <= cnt_base + 16'd1;
        stat_q <= {5'd0, rx_align_err, rx_crc_err, ~(rx_crc_err | rx_align_err)};
      end else begin
        st_q   <= S_RECV;
        wpg_q  <= npos_pg;
        woff_q <= npos_off;
        cnt_q  <= cnt_base + 16'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstart_q <= PSTART_INIT;
      pstop_q  <= PSTOP_INIT;
      bnry_q   <= PSTOP_INIT - 8'd1;
      curr_q   <= PSTART_INIT;
    end else begin
      if (reg_we && reg_addr == 3'd0) pstart_q <= reg_wdata;
      if (reg_we && reg_addr == 3'd1) pstop_q  <= reg_wdata;
      if (reg_we && reg_addr == 3'd1) bnry_q   <= reg_wdata - 8'd1;
      else if (reg_we && reg_addr == 3'd2) bnry_q <= reg_wdata;
      if (hdr_done) curr_q <= nxt_q;
      else if (reg_we && (reg_addr == 3'd0 || reg_addr == 3'd3)) curr_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prx_q <= 1'b0;
      ovw_q <= 1'b0;
    end else begin
      prx_q <= (prx_q & ~(reg_we && reg_addr == 3'd4 && reg_wdata[0])) | hdr_done;
      ovw_q <= (ovw_q & ~(reg_we && reg_addr == 3'd4 && reg_wdata[4])) | (take && blocked);
    end
  end
endmodule

// File: rtl/rx_page_ring_chk.sv
module rx_page_ring_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  pstart_q,
  input logic [7:0]  pstop_q,
  input logic [7:0]  bnry_q,
  input logic [7:0]  curr_q,
  input logic [1:0]  st_q,
  input logic [1:0]  hidx_q,
  input logic        prx_q,
  input logic        reg_we
);
  p_in_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] >= pstart_q && mem_addr[15:8] < pstop_q));

  p_skip_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st_q != 2'd3) |-> (mem_addr[15:8] != bnry_q));

  p_header_place_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st_q == 2'd3) |-> (mem_addr[15:8] == curr_q && mem_addr[7:2] == 6'd0));

  p_curr_moves_late_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_we) && !$stable(curr_q)) |-> $past(st_q == 2'd3 && hidx_q == 2'd3));

  p_prx_at_header_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prx_q) |-> $past(st_q == 2'd3 && hidx_q == 2'd3));
endmodule

bind rx_page_ring rx_page_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_we(mem_we), .mem_addr(mem_addr),
  .pstart_q(pstart_q), .pstop_q(pstop_q), .bnry_q(bnry_q), .curr_q(curr_q),
  .st_q(st_q), .hidx_q(hidx_q), .prx_q(prx_q), .reg_we(reg_we)
);

// File: tb/tb_rx_page_ring.sv
module tb_rx_page_ring;
  localparam int PS = 4;
  localparam int PE = 12;
  localparam int RING = (PE - PS) * 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0] rx_data = 8'd0;
  logic rx_crc_err = 1'b0, rx_align_err = 1'b0;
  logic mem_we;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata;
  logic irq_prx, irq_ovw;

  logic [7:0] mem [0:4095];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rx_page_ring dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .irq_prx(irq_prx), .irq_ovw(irq_ovw)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(int a, output int v);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 v = int'(reg_rdata);
  endtask

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed + i * 7) & 8'hFF);
  endfunction

  function automatic int byte_addr(int pg, int i);
    return PS * 256 + (((pg - PS) * 256 + 4 + i) % RING);
  endfunction

  function automatic int next_page(int pg, int n);
    return PS + (((pg - PS) + (3 + n) / 256 + 1) % (PE - PS));
  endfunction

  task automatic send(int n, bit crc, bit aln, int seed, bit collide);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_data = pat(seed, i);
      rx_crc_err = crc && (i == n - 1); rx_align_err = aln && (i == n - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_err = 1'b0; rx_align_err = 1'b0;
    if (collide) begin
      repeat (3) @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h01;
      @(negedge clk);
      reg_we = 1'b0;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic check_frame(string req, int pg, int n, int st, int seed);
    int bad = 0;
    check({req, " R4 R5 status"}, int'(mem[pg * 256 + 0]), st);
    check({req, " R4 next page"}, int'(mem[pg * 256 + 1]), next_page(pg, n));
    check({req, " R6 count low"}, int'(mem[pg * 256 + 2]), n & 255);
    check({req, " R6 count high"}, int'(mem[pg * 256 + 3]), n >> 8);
    for (int i = 0; i < n; i++)
      if (mem[byte_addr(pg, i)] != pat(seed, i)) bad++;
    check({req, " R3 data bytes mismatched"}, bad, 0);
  endtask

  task automatic t_reset();
    int v;
    reg_rd(0, v); check("R1 start page", v, 8'h40);
    reg_rd(1, v); check("R1 stop page", v, 8'h80);
    reg_rd(2, v); check("R1 boundary", v, 8'h7F);
    reg_rd(3, v); check("R1 current", v, 8'h40);
    reg_rd(4, v); check("R1 status", v, 0);
    reg_wr(0, PS); reg_wr(1, PE);
    reg_rd(3, v); check("R2 current loaded by start write", v, PS);
    reg_rd(2, v); check("R2 boundary loaded by stop write", v, PE - 1);
    reg_wr(3, 9); reg_rd(3, v); check("R2 current write", v, 9);
    reg_wr(3, PS);
  endtask

  task automatic t_single();
    int v;
    send(60, 0, 0, 3, 0);
    check_frame("single", PS, 60, 8'h01, 3);
    reg_rd(3, v); check("R8 current after frame", v, PS + 1);
    reg_rd(4, v); check("R8 R10 received flag", v, 8'h01);
    reg_wr(4, 8'h01); reg_rd(4, v); check("R10 clear received", v, 0);
  endtask

  task automatic t_errors();
    int v;
    send(100, 1, 0, 11, 0);
    check_frame("crc", 5, 100, 8'h02, 11);
    send(100, 0, 1, 19, 0);
    check_frame("align", 6, 100, 8'h04, 19);
    reg_rd(3, v); check("R8 current after error frames", v, 7);
    reg_wr(4, 8'h01);
  endtask

  task automatic t_multipage();
    int v;
    send(600, 0, 0, 23, 0);
    check_frame("multipage", 7, 600, 8'h01, 23);
    reg_rd(3, v); check("R8 current after 3 pages", v, 10);
  endtask

  task automatic t_wrap();
    int v;
    reg_wr(2, 9);
    send(700, 0, 0, 41, 0);
    check_frame("wrap R7", 10, 700, 8'h01, 41);
    check("R7 first byte of start page", int'(mem[PS * 256]), int'(pat(41, 508)));
    reg_rd(3, v); check("R7 current wrapped", v, 5);
    reg_wr(4, 8'h01);
  endtask

  task automatic t_overflow();
    int v;
    reg_wr(2, 6);
    mem[6 * 256] = 8'hA5;
    mem[5 * 256] = 8'h5A;
    send(400, 0, 0, 57, 0);
    check("R9 boundary page untouched", int'(mem[6 * 256]), 8'hA5);
    check("R9 no header written", int'(mem[5 * 256]), 8'h5A);
    reg_rd(4, v); check("R9 R10 overwrite flag only", v, 8'h10);
    reg_rd(3, v); check("R9 current unchanged", v, 5);
    reg_wr(4, 8'h10); reg_rd(4, v); check("R10 clear overwrite", v, 0);
    reg_wr(2, 5);
    send(10, 0, 0, 61, 0);
    reg_rd(4, v); check("R9 start at boundary flagged", v, 8'h10);
    reg_rd(3, v); check("R9 current unchanged at start", v, 5);
    reg_wr(4, 8'h10);
    reg_wr(2, 4);
    send(60, 0, 0, 67, 0);
    check_frame("after free", 5, 60, 8'h01, 67);
    reg_rd(3, v); check("R8 current after freeing", v, 6);
    reg_wr(4, 8'h01);
  endtask

  task automatic t_collision();
    int v;
    send(60, 0, 0, 71, 1);
    reg_rd(4, v); check("R10 set wins over clear", v, 8'h01);
    reg_rd(3, v); check("R8 current after collision frame", v, 7);
    reg_wr(4, 8'h01); reg_rd(4, v); check("R10 later clear", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_errors();
    t_multipage();
    t_wrap();
    t_overflow();
    t_collision();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule